// File: doc/BRIEF.md
# Memory BAR Decoder with Zero-Base Disable

This block is a single 32-bit memory base address register for a PCI-style target, paired with the comparator that turns a bus address into a hit. Configuration software reaches it through a small register port: a dword offset, four byte enables, write data and combinational read data. The BAR claims one naturally aligned memory window of 2^WIN_LOG2 bytes, which is 4 KB by default. The usual sizing handshake works: software writes all ones and reads back the mask.

A base of all zeros is special. By default, a BAR whose writable bits are all zero counts as unassigned and never claims an address. This lets software leave a function partly configured. A control bit in the vendor-defined part of configuration space can change this. Once software sets it, a zero base is an ordinary address and the window sits at the very bottom of memory. The hit output also needs the memory-enable bit of the command register.

The hit output is combinational from the registered state and the incoming bus address. A configuration write therefore changes the decode on the cycle after the write edge.

Top module: `membar_decoder`

## Requirements
- R1: After synchronous reset, the BAR (dword 4, byte 0x10), the command register (dword 1, byte 0x04) and the control register (dword 16, byte 0x40) all read 0x00000000, and bar_hit is low.
- R2: BAR read data bits [11:0] are always zero: bit 0 = 0 (memory), bits [2:1] = 00 (32-bit), bit 3 = 0 (non-prefetchable), and bits [11:4] = 0, whatever was written.
- R3: Writing 0xFFFFFFFF with all byte enables to the BAR makes it read 0xFFFFF000.
- R4: A write changes only the bytes whose enable bit is set (cfg_be[n] covers bits [8n+7:8n]). With cfg_we low, nothing changes.
- R5: bar_hit is never high while command bit 1 (memory enable) is clear.
- R6: With memory enable set and a non-zero base, bar_hit is high exactly when bus_addr[31:12] equals BAR bits [31:12].
- R7: While BAR bits [31:12] are all zero and control bit 0 is clear, bar_hit stays low for every address.
- R8: Control register bit 0 (zero-base-valid) resets to 0. When it is set, a zero base decodes bus addresses 0x00000000 to 0x00000FFF. All other control bits read 0.
- R9: A base written at a clock edge sets bar_hit from that edge on, and not before it.
- R10: Writes to offsets other than dword 1, 4 and 16 leave the three registers unchanged, and those other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword offset |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_dw_addr |
| bus_addr | input | 32 | Bus address to decode |
| bar_hit | output | 1 | Address falls in the enabled window |

## Verification
Suppose a wrong bit is stored in the base. It shows up on the next BAR read-back, and bar_hit goes wrong in the same cycle for any probe address near the intended window. A stuck or mis-reset zero-base-valid bit or memory-enable bit shows up as a hit that appears or goes missing on the very first probe after the write. The probes at address 0 and just past 0xFFF are there to catch these. A byte-lane mix-up shows up after a single partial write, because each lane is written with a different byte value.

// File: rtl/membar_pkg.sv
package membar_pkg;

    localparam int ADDR_W     = 32;
    localparam int DW_IDX_W   = 6;
    localparam int LANES      = ADDR_W / 8;
    localparam int WIN_LOG2_D = 12;

    localparam logic [DW_IDX_W-1:0] CMD_DW = 6'd1;
    localparam logic [DW_IDX_W-1:0] BAR_DW = 6'd4;
    localparam logic [DW_IDX_W-1:0] CTL_DW = 6'd16;

    localparam int MEM_EN_BIT  = 1;
    localparam int ZERO_OK_BIT = 0;

    typedef struct packed {
        logic                we;
        logic [DW_IDX_W-1:0] dw;
        logic [LANES-1:0]    be;
        logic [ADDR_W-1:0]   data;
    } cfg_wr_t;

    typedef struct packed {
        logic mem_en;
        logic zero_ok;
    } bar_ctl_t;

    function automatic logic lane_write(input cfg_wr_t w,
                                        input logic [DW_IDX_W-1:0] dw,
                                        input int lane);
        return w.we && (w.dw == dw) && w.be[lane];
    endfunction

endpackage

// File: rtl/membar_cfg_regs.sv
module membar_cfg_regs
    import membar_pkg::*;
#(
    parameter int WIN_LOG2 = WIN_LOG2_D,
    localparam int BASE_W = ADDR_W - WIN_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_wr_t           wr,
    input  logic [DW_IDX_W-1:0] rd_dw,
    output logic [ADDR_W-1:0] rd_data,
    output logic [BASE_W-1:0] base_q,
    output bar_ctl_t          ctl_q
);

    logic [BASE_W-1:0] base_next;

    // Each writable base bit follows the enable of its own byte lane.
    for (genvar i = 0; i < BASE_W; i++) begin : g_base_bit
        localparam int ABIT = i + WIN_LOG2;
        localparam int LANE = ABIT / 8;
        assign base_next[i] = lane_write(wr, BAR_DW, LANE) ? wr.data[ABIT] : base_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ctl_q  <= '0;
        end else begin
            base_q <= base_next;
            if (lane_write(wr, CMD_DW, MEM_EN_BIT / 8))
                ctl_q.mem_en <= wr.data[MEM_EN_BIT];
            if (lane_write(wr, CTL_DW, ZERO_OK_BIT / 8))
                ctl_q.zero_ok <= wr.data[ZERO_OK_BIT];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_dw)
            CMD_DW:  rd_data[MEM_EN_BIT]  = ctl_q.mem_en;
            BAR_DW:  rd_data              = {base_q, {WIN_LOG2{1'b0}}};
            CTL_DW:  rd_data[ZERO_OK_BIT] = ctl_q.zero_ok;
            default: rd_data              = '0;
        endcase
    end

endmodule

// File: rtl/membar_match.sv
module membar_match
    import membar_pkg::*;
#(
    parameter int WIN_LOG2 = WIN_LOG2_D,
    localparam int BASE_W = ADDR_W - WIN_LOG2
) (
    input  logic [BASE_W-1:0] base,
    input  bar_ctl_t          ctl,
    input  logic [BASE_W-1:0] addr_hi,
    output logic              hit
);

    logic base_zero;
    logic unassigned;
    logic addr_eq;

    // The zero detect looks only at the writable base bits.
    assign base_zero  = ~|base;
    assign unassigned = base_zero & ~ctl.zero_ok;
    assign addr_eq    = (addr_hi == base);
    assign hit        = ctl.mem_en & ~unassigned & addr_eq;

endmodule

// File: rtl/membar_decoder.sv
module membar_decoder
    import membar_pkg::*;
#(
    parameter int WIN_LOG2 = WIN_LOG2_D
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [DW_IDX_W-1:0] cfg_dw_addr,
    input  logic [LANES-1:0]    cfg_be,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic [ADDR_W-1:0]   cfg_rdata,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic                bar_hit
);

    localparam int BASE_W = ADDR_W - WIN_LOG2;

    cfg_wr_t           wr;
    logic [BASE_W-1:0] base_q;
    bar_ctl_t          ctl_q;
    logic              mem_en;
    logic              zero_ok;

    assign wr      = '{we: cfg_we, dw: cfg_dw_addr, be: cfg_be, data: cfg_wdata};
    assign mem_en  = ctl_q.mem_en;
    assign zero_ok = ctl_q.zero_ok;

    membar_cfg_regs #(.WIN_LOG2(WIN_LOG2)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_dw   (cfg_dw_addr),
        .rd_data (cfg_rdata),
        .base_q  (base_q),
        .ctl_q   (ctl_q)
    );

    membar_match #(.WIN_LOG2(WIN_LOG2)) u_match (
        .base    (base_q),
        .ctl     (ctl_q),
        .addr_hi (bus_addr[ADDR_W-1:WIN_LOG2]),
        .hit     (bar_hit)
    );

endmodule

// File: rtl/membar_decoder_chk.sv
module membar_decoder_chk
    import membar_pkg::*;
#(
    parameter int WIN_LOG2 = WIN_LOG2_D,
    localparam int BASE_W = ADDR_W - WIN_LOG2
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_we,
    input logic [DW_IDX_W-1:0] cfg_dw_addr,
    input logic [ADDR_W-1:0]   cfg_rdata,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bar_hit,
    input logic [BASE_W-1:0]   base_q,
    input logic                mem_en,
    input logic                zero_ok
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (base_q == '0 && !mem_en && !zero_ok));

    p_bar_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_dw_addr == BAR_DW) |-> (cfg_rdata[WIN_LOG2-1:0] == '0));

    p_no_write_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(base_q) && $stable(mem_en) && $stable(zero_ok)));

    p_hit_needs_mem_r5: assert property (@(posedge clk) disable iff (rst)
        bar_hit |-> mem_en);

    p_hit_matches_r6: assert property (@(posedge clk) disable iff (rst)
        bar_hit |-> (bus_addr[ADDR_W-1:WIN_LOG2] == base_q));

    p_zero_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        (base_q == '0 && !zero_ok) |-> !bar_hit);

    p_zero_ok_hit_r8: assert property (@(posedge clk) disable iff (rst)
        (base_q == '0 && zero_ok && mem_en && bus_addr[ADDR_W-1:WIN_LOG2] == '0) |-> bar_hit);

endmodule

bind membar_decoder membar_decoder_chk #(.WIN_LOG2(WIN_LOG2)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_dw_addr (cfg_dw_addr),
    .cfg_rdata   (cfg_rdata),
    .bus_addr    (bus_addr),
    .bar_hit     (bar_hit),
    .base_q      (base_q),
    .mem_en      (mem_en),
    .zero_ok     (zero_ok)
);

// File: tb/test_membar_decoder.sv
`timescale 1ns/1ps
module test_membar_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [5:0]  cfg_dw_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [31:0] bus_addr;
    logic        bar_hit;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    membar_decoder i_membar_decoder (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dw_addr(cfg_dw_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_addr(bus_addr), .bar_hit(bar_hit)
    );

    typedef struct packed {
        logic [5:0]  dw;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] probe;
        logic        exp_hit;
        logic [31:0] exp_bar;
        logic [7:0]  req;
    } vec_t;

    // Each row: one write, then a probe of bar_hit and a BAR read-back.
    localparam vec_t VECS [11] = '{
        '{6'd1,  4'h1, 32'h0000_0002, 32'h0000_0000, 1'b0, 32'h0000_0000, 8'd7}, // R7 mem on, base 0
        '{6'd4,  4'hF, 32'hFFFF_FFFF, 32'hFFFF_F123, 1'b1, 32'hFFFF_F000, 8'd3}, // R3 sizing
        '{6'd4,  4'hF, 32'h1234_5678, 32'h1234_5ABC, 1'b1, 32'h1234_5000, 8'd6}, // R6
        '{6'd4,  4'h0, 32'hFFFF_FFFF, 32'h1234_6000, 1'b0, 32'h1234_5000, 8'd4}, // R4 no lanes
        '{6'd4,  4'h8, 32'hAB00_0000, 32'hAB34_5FFF, 1'b1, 32'hAB34_5000, 8'd4}, // R4 lane 3
        '{6'd4,  4'h2, 32'h0000_CD00, 32'hAB34_C000, 1'b1, 32'hAB34_C000, 8'd4}, // R4 lane 1
        '{6'd4,  4'h4, 32'h0077_0000, 32'hAB34_C000, 1'b0, 32'hAB77_C000, 8'd6}, // R6 miss
        '{6'd4,  4'hF, 32'h0000_0000, 32'h0000_0010, 1'b0, 32'h0000_0000, 8'd7}, // R7
        '{6'd16, 4'h1, 32'h0000_0001, 32'h0000_0FFF, 1'b1, 32'h0000_0000, 8'd8}, // R8
        '{6'd16, 4'h0, 32'h0000_0000, 32'h0000_1000, 1'b0, 32'h0000_0000, 8'd8}, // R8 edge
        '{6'd1,  4'h1, 32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 8'd5}  // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dw_addr = dw; cfg_be = be; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [5:0] dw, output logic [31:0] d);
        cfg_dw_addr = dw;
        #1 d = cfg_rdata;
    endtask

    task automatic probe(input logic [31:0] a, output logic h);
        bus_addr = a;
        #1 h = bar_hit;
    endtask

    initial begin
        logic [31:0] rd;
        logic        h;
        rst = 1'b1; cfg_we = 1'b0; cfg_dw_addr = '0; cfg_be = '0;
        cfg_wdata = '0; bus_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        cfg_read(6'd4, rd);  check("R1 bar", rd, 32'h0);
        cfg_read(6'd1, rd);  check("R1 cmd", rd, 32'h0);
        cfg_read(6'd16, rd); check("R1 ctl", rd, 32'h0);
        probe(32'h0, h);     check("R1 hit", {31'b0, h}, 32'h0);

        foreach (VECS[k]) begin
            cfg_write(VECS[k].dw, VECS[k].be, VECS[k].wdata);
            probe(VECS[k].probe, h);
            check($sformatf("R%0d vec%0d hit", VECS[k].req, k), {31'b0, h}, {31'b0, VECS[k].exp_hit});
            cfg_read(6'd4, rd);
            check($sformatf("R%0d vec%0d bar", VECS[k].req, k), rd, VECS[k].exp_bar);
        end

        // R2: low bits never stored
        cfg_write(6'd4, 4'h3, 32'h0000_0FFF);
        cfg_read(6'd4, rd); check("R2 low bits", rd, 32'h0000_0000);

        // R8: only bit 0 of control exists (bit is currently 1)
        cfg_write(6'd16, 4'hF, 32'hFFFF_FFFE);
        cfg_read(6'd16, rd); check("R8 ctl clear", rd, 32'h0);
        cfg_write(6'd16, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'd16, rd); check("R8 ctl width", rd, 32'h1);

        // R9: new base takes effect at the write edge, not before
        cfg_write(6'd1, 4'h1, 32'h2);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dw_addr = 6'd4; cfg_be = 4'hF; cfg_wdata = 32'h5000_0000;
        bus_addr = 32'h5000_0040;
        #1 check("R9 before edge", {31'b0, bar_hit}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        #1 check("R9 after edge", {31'b0, bar_hit}, 32'h1);

        // R10: other offsets ignored
        cfg_write(6'd5, 4'hF, 32'hFFFF_FFFF);
        cfg_write(6'd0, 4'hF, 32'h0000_0000);
        cfg_write(6'd17, 4'hF, 32'h0000_0000);
        cfg_read(6'd4, rd);  check("R10 bar kept", rd, 32'h5000_0000);
        cfg_read(6'd1, rd);  check("R10 cmd kept", rd, 32'h2);
        cfg_read(6'd16, rd); check("R10 ctl kept", rd, 32'h1);
        cfg_read(6'd5, rd);  check("R10 other reads 0", rd, 32'h0);
        probe(32'h5000_0FFC, h); check("R10 hit kept", {31'b0, h}, 32'h1);

        // R1: reset again clears everything
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        @(negedge clk) rst = 1'b0;
        cfg_read(6'd4, rd);  check("R1 bar re-reset", rd, 32'h0);
        cfg_read(6'd16, rd); check("R1 ctl re-reset", rd, 32'h0);
        probe(32'h0, h);     check("R1 hit re-reset", {31'b0, h}, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule